// File: doc/BRIEF.md
# BCD Calendar Real-Time Counter

This block keeps the time of day and the calendar date as counters and presents every field to software as a packed BCD byte. The fields are seconds, minutes, hours, day of month, month and two-digit year, plus a weekday. A separate prescaler delivers a one-second strobe on `tick_i`. While the run bit is set, each strobe moves the time on by one second. Carries ripple from seconds through to the year, and the month length and leap years are taken into account.

Software reaches the block through a byte-wide write/read bus. There is one register per 4-byte offset, and reads are combinational. A control register selects 24-hour or 12-hour presentation of the hours field and enables auto-compensation for a neighbouring drift block. It also holds a one-shot command that snaps the seconds to the nearest minute. The alarm, interrupt and compensation logic sit outside. This block gives them the current fields in BCD, the compensation enable, and one-cycle wrap strobes.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0. The control register reads 0x00 and all wrap strobes are low.
- R2: The time fields sit at byte offsets 0x00 seconds, 0x04 minutes, 0x08 hours, 0x0C day, 0x10 month and 0x14 year. Each is written and read as packed BCD, with the tens digit in bits 7:4 and the units in bits 3:0. Month is 1–12 and year is 00–99. An unmapped offset reads 0x00.
- R3: Offset 0x18 reads the weekday as plain binary 0–6. Writes to it are ignored.
- R4: The control register at 0x40 reads back its written value in the same layout: bit 0 run, bit 1 round, bit 2 auto-compensation enable, bit 3 12-hour mode. Bit 2 drives `acomp_en_o`.
- R5: A tick moves the time on by exactly one second when run is 1. With run 0 and round 0, a tick leaves every field unchanged.
- R6: Seconds wrap 59→0 and advance minutes. Minutes wrap 59→0 and advance hours. Hours wrap 23→0 and advance the day. On each wrap, `sec_wrap_o`, `min_wrap_o` or `hour_wrap_o` is high for one cycle, in the same cycle the new value appears.
- R7: The day wraps to 1 after the last day of the month: 28 or 29 for month 2, 30 for months 4, 6, 9 and 11, and 31 otherwise. A year whose value is divisible by 4 is a leap year. On this wrap the month advances, `day_wrap_o` pulses, and the weekday advances modulo 7. Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R8: In 12-hour mode the hours register reads bit 7 = PM (internal hour 12–23) and bits 5:0 = the hour 1–12 in BCD, with hour 0 shown as 12 AM. Writes use the same form. `hour_o` always stays in 24-hour BCD.
- R9: With round set, the next tick sets seconds below 30 to 0 with no minute change and no strobe. Seconds of 30 or more go to 0 with a minute carry and a `sec_wrap_o` strobe. That tick adds no other second, applies even with run 0, and clears the round bit.
- R10: A bus write takes effect at the next clock edge. A tick arriving in a cycle with a bus write is held and applied in the next cycle without a write, so no second is lost.
- R11: `sec_o`, `min_o`, `day_o`, `mon_o` and `year_o` show the current fields in packed BCD, and `wday_o` shows the weekday in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| wr_en_i | input | 1 | Bus write enable |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, 24-hour BCD |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD 00–99 |
| wday_o | output | 3 | Weekday 0–6 |
| acomp_en_o | output | 1 | Auto-compensation enable |
| sec_wrap_o | output | 1 | Seconds wrapped to 0 |
| min_wrap_o | output | 1 | Minutes wrapped to 0 |
| hour_wrap_o | output | 1 | Hours wrapped to 0 |
| day_wrap_o | output | 1 | Day wrapped to 1 |

## Verification
A wrong counter state shows on the BCD outputs one cycle after the tick that caused it. A missing carry shows as a field that stays put while its lower neighbour returns to zero, and a wrong month limit shows as a day of 29, 30 or 31 where it should have been 1. Wrong 12-hour formatting shows only at offset 0x08, while `hour_o` still reads correctly. A round or deferral fault shows on the first tick after the command or the collision, as a stray or missing second. The sweeps therefore cover every field value, every month of a four-year leap cycle, and every seconds value under the round command.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;
  localparam int WDAY_W = 3;

  localparam int OFS_SEC  = 'h00;
  localparam int OFS_MIN  = 'h04;
  localparam int OFS_HOUR = 'h08;
  localparam int OFS_DAY  = 'h0C;
  localparam int OFS_MON  = 'h10;
  localparam int OFS_YEAR = 'h14;
  localparam int OFS_WDAY = 'h18;
  localparam int OFS_CTRL = 'h40;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2: return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_wrap_cnt.sv
module cal_wrap_cnt #(
  parameter int W   = 6,
  parameter int LOW = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LOW_V = W'(LOW);

  logic [W-1:0] q_q;

  // >= lets an out-of-range written value wrap instead of running away
  assign carry_o = inc_i & ~wr_i & ~clr_i & (q_q >= lim_i);
  assign q_o     = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= LOW_V;
    else if (wr_i)      q_q <= wr_val_i;
    else if (clr_i)     q_q <= LOW_V;
    else if (inc_i)     q_q <= (q_q >= lim_i) ? LOW_V : q_q + W'(1);
  end

  AST_CARRY_TO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (q_o == LOW_V)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i && !wr_i) |=> $stable(q_o)); // R5
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       any_wr_i,
  input  logic       wr_ctrl_i,
  input  logic [3:0] wdata_i,
  output logic       run_o,
  output logic       round_o,
  output logic       acomp_o,
  output logic       h12_o,
  output logic       tick_go_o
);
  logic pend_q, run_q, round_q, acomp_q, h12_q;
  logic tick_eff;

  // a tick colliding with a write is held one cycle
  assign tick_eff  = tick_i | pend_q;
  assign tick_go_o = tick_eff & ~any_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      round_q <= 1'b0;
      acomp_q <= 1'b0;
      h12_q   <= 1'b0;
    end else begin
      pend_q <= tick_eff & any_wr_i;
      if (wr_ctrl_i) begin
        run_q   <= wdata_i[0];
        round_q <= wdata_i[1];
        acomp_q <= wdata_i[2];
        h12_q   <= wdata_i[3];
      end else if (tick_go_o) begin
        round_q <= 1'b0;
      end
    end
  end

  assign run_o   = run_q;
  assign round_o = round_q;
  assign acomp_o = acomp_q;
  assign h12_o   = h12_q;

  AST_ROUND_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (round_q && tick_go_o) |=> !round_q); // R9
  AST_TICK_DEFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && any_wr_i) |=> (tick_go_o || any_wr_i)); // R10
endmodule

// File: rtl/cal_rd_mux.sv
module cal_rd_mux #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [cal_pkg::SEC_W-1:0]  sec_i,
  input  logic [cal_pkg::MIN_W-1:0]  min_i,
  input  logic [cal_pkg::HOUR_W-1:0] hour_i,
  input  logic [cal_pkg::DAY_W-1:0]  day_i,
  input  logic [cal_pkg::MON_W-1:0]  mon_i,
  input  logic [cal_pkg::YEAR_W-1:0] year_i,
  input  logic [cal_pkg::WDAY_W-1:0] wday_i,
  input  logic [3:0]                 ctrl_i,
  output logic [7:0]                 rdata_o
);
  import cal_pkg::*;

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(OFS_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(OFS_HOUR);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(OFS_DAY);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(OFS_MON);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(OFS_YEAR);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(OFS_WDAY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic                pm;
  logic [HOUR_W-1:0]   h12n;
  logic [7:0]          hour_rd;

  always_comb begin
    pm   = (hour_i >= HOUR_W'(12));
    h12n = pm ? hour_i - HOUR_W'(12) : hour_i;
    if (h12n == '0) h12n = HOUR_W'(12);
    hour_rd = ctrl_i[3] ? (bin2bcd(7'(h12n)) | {pm, 7'd0}) : bin2bcd(7'(hour_i));
  end

  always_comb begin
    if      (addr_i == A_SEC)  rdata_o = bin2bcd(7'(sec_i));
    else if (addr_i == A_MIN)  rdata_o = bin2bcd(7'(min_i));
    else if (addr_i == A_HOUR) rdata_o = hour_rd;
    else if (addr_i == A_DAY)  rdata_o = bin2bcd(7'(day_i));
    else if (addr_i == A_MON)  rdata_o = bin2bcd(7'(mon_i));
    else if (addr_i == A_YEAR) rdata_o = bin2bcd(year_i);
    else if (addr_i == A_WDAY) rdata_o = 8'(wday_i);
    else if (addr_i == A_CTRL) rdata_o = {4'd0, ctrl_i};
    else                       rdata_o = 8'd0;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        day_o,
  output logic [7:0]        mon_o,
  output logic [7:0]        year_o,
  output logic [2:0]        wday_o,
  output logic              acomp_en_o,
  output logic              sec_wrap_o,
  output logic              min_wrap_o,
  output logic              hour_wrap_o,
  output logic              day_wrap_o
);
  import cal_pkg::*;

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(OFS_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(OFS_HOUR);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(OFS_DAY);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(OFS_MON);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(OFS_YEAR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic run, round, acomp, h12, tick_go;
  logic step, round_go, round_up;
  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  min;
  logic [HOUR_W-1:0] hour;
  logic [DAY_W-1:0]  day, dim;
  logic [MON_W-1:0]  mon;
  logic [YEAR_W-1:0] year;
  logic [WDAY_W-1:0] wday;
  logic sec_c, min_c, hour_c, day_c, mon_c, year_c, wday_c;
  logic [6:0] wval, h12v;
  logic [HOUR_W-1:0] hour_wv;
  logic sec_wrap_q, min_wrap_q, hour_wrap_q, day_wrap_q;

  cal_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .any_wr_i  (wr_en_i),
    .wr_ctrl_i (wr_en_i && addr_i == A_CTRL),
    .wdata_i   (wdata_i[3:0]),
    .run_o     (run),
    .round_o   (round),
    .acomp_o   (acomp),
    .h12_o     (h12),
    .tick_go_o (tick_go)
  );

  // a round tick only snaps, it adds no second
  assign step     = tick_go & run & ~round;
  assign round_go = tick_go & round;
  assign round_up = round_go & (sec >= SEC_W'(30));

  assign wval    = bcd2bin(wdata_i);
  assign h12v    = bcd2bin({2'b00, wdata_i[5:0]});
  assign hour_wv = h12 ? HOUR_W'((h12v % 7'd12) + (wdata_i[7] ? 7'd12 : 7'd0))
                       : wval[HOUR_W-1:0];
  assign dim     = month_days(mon, year[1:0] == 2'b00);

  cal_wrap_cnt #(.W(SEC_W), .LOW(0)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(step), .clr_i(round_go),
    .wr_i(wr_en_i && addr_i == A_SEC), .wr_val_i(wval[SEC_W-1:0]),
    .lim_i(SEC_W'(59)), .q_o(sec), .carry_o(sec_c));

  cal_wrap_cnt #(.W(MIN_W), .LOW(0)) u_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_c | round_up), .clr_i(1'b0),
    .wr_i(wr_en_i && addr_i == A_MIN), .wr_val_i(wval[MIN_W-1:0]),
    .lim_i(MIN_W'(59)), .q_o(min), .carry_o(min_c));

  cal_wrap_cnt #(.W(HOUR_W), .LOW(0)) u_hour (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_c), .clr_i(1'b0),
    .wr_i(wr_en_i && addr_i == A_HOUR), .wr_val_i(hour_wv),
    .lim_i(HOUR_W'(23)), .q_o(hour), .carry_o(hour_c));

  cal_wrap_cnt #(.W(DAY_W), .LOW(1)) u_day (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hour_c), .clr_i(1'b0),
    .wr_i(wr_en_i && addr_i == A_DAY), .wr_val_i(wval[DAY_W-1:0]),
    .lim_i(dim), .q_o(day), .carry_o(day_c));

  cal_wrap_cnt #(.W(MON_W), .LOW(1)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(day_c), .clr_i(1'b0),
    .wr_i(wr_en_i && addr_i == A_MON), .wr_val_i(wval[MON_W-1:0]),
    .lim_i(MON_W'(12)), .q_o(mon), .carry_o(mon_c));

  cal_wrap_cnt #(.W(YEAR_W), .LOW(0)) u_year (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(mon_c), .clr_i(1'b0),
    .wr_i(wr_en_i && addr_i == A_YEAR), .wr_val_i(wval),
    .lim_i(YEAR_W'(99)), .q_o(year), .carry_o(year_c));

  // weekday has no write path
  cal_wrap_cnt #(.W(WDAY_W), .LOW(0)) u_wday (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(day_c), .clr_i(1'b0),
    .wr_i(1'b0), .wr_val_i('0),
    .lim_i(WDAY_W'(6)), .q_o(wday), .carry_o(wday_c));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_wrap_q  <= 1'b0;
      min_wrap_q  <= 1'b0;
      hour_wrap_q <= 1'b0;
      day_wrap_q  <= 1'b0;
    end else begin
      sec_wrap_q  <= sec_c | round_up;
      min_wrap_q  <= min_c;
      hour_wrap_q <= hour_c;
      day_wrap_q  <= day_c;
    end
  end

  cal_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr_i (addr_i),
    .sec_i  (sec),
    .min_i  (min),
    .hour_i (hour),
    .day_i  (day),
    .mon_i  (mon),
    .year_i (year),
    .wday_i (wday),
    .ctrl_i ({h12, acomp, round, run}),
    .rdata_o(rdata_o)
  );

  assign sec_o       = bin2bcd(7'(sec));
  assign min_o       = bin2bcd(7'(min));
  assign hour_o      = bin2bcd(7'(hour));
  assign day_o       = bin2bcd(7'(day));
  assign mon_o       = bin2bcd(7'(mon));
  assign year_o      = bin2bcd(year);
  assign wday_o      = wday;
  assign acomp_en_o  = acomp;
  assign sec_wrap_o  = sec_wrap_q;
  assign min_wrap_o  = min_wrap_q;
  assign hour_wrap_o = hour_wrap_q;
  assign day_wrap_o  = day_wrap_q;

  AST_MIN_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_wrap_o |-> sec_wrap_o); // R6
  AST_WDAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday <= WDAY_W'(6)); // R7
  AST_WDAY_WITH_DAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday_c |-> day_c); // R7
  AST_YEAR_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_c |-> (mon_c && day_c)); // R7
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !round && !wr_en_i) |=> $stable(sec_o)); // R5
endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, sec_o, min_o, hour_o, day_o, mon_o, year_o;
  logic [2:0] wday_o;
  logic       acomp_en_o, sec_wrap_o, min_wrap_o, hour_wrap_o, day_wrap_o;

  int n_vec = 0;
  int n_err = 0;
  int exp_wd = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  bcd_rtc_core #(.ADDR_W(7)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .mon_o(mon_o), .year_o(year_o), .wday_o(wday_o), .acomp_en_o(acomp_en_o),
    .sec_wrap_o(sec_wrap_o), .min_wrap_o(min_wrap_o),
    .hour_wrap_o(hour_wrap_o), .day_wrap_o(day_wrap_o));

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int fmt12(int h);
    int hh;
    hh = h % 12;
    if (hh == 0) hh = 12;
    return ((h >= 12) ? 'h80 : 0) | bcd(hh);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 7'(a);
    #1;
    d = rdata;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input int y, input int mo, input int d, input int h, input int mi, input int s);
    wr('h14, bcd(y)); wr('h10, bcd(mo)); wr('h0C, bcd(d));
    wr('h08, bcd(h)); wr('h04, bcd(mi)); wr('h00, bcd(s));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd('h00, rv); chk("R1 sec", rv, 'h00);
    rd('h04, rv); chk("R1 min", rv, 'h00);
    rd('h08, rv); chk("R1 hour", rv, 'h00);
    rd('h0C, rv); chk("R1 day", rv, 'h01);
    rd('h10, rv); chk("R1 mon", rv, 'h01);
    rd('h14, rv); chk("R1 year", rv, 'h00);
    rd('h18, rv); chk("R1 wday", rv, 0);
    rd('h40, rv); chk("R1 ctrl", rv, 0);
    chk("R1 strobes", {sec_wrap_o, min_wrap_o, hour_wrap_o, day_wrap_o}, 0);

    // R2 exhaustive write/readback of every field value
    for (int v = 0; v < 60; v++) begin wr('h00, bcd(v)); rd('h00, rv); chk("R2 sec", rv, bcd(v)); end
    for (int v = 0; v < 60; v++) begin wr('h04, bcd(v)); rd('h04, rv); chk("R2 min", rv, bcd(v)); end
    for (int v = 0; v < 24; v++) begin wr('h08, bcd(v)); rd('h08, rv); chk("R2 hour", rv, bcd(v)); end
    for (int v = 1; v < 32; v++) begin wr('h0C, bcd(v)); rd('h0C, rv); chk("R2 day", rv, bcd(v)); end
    for (int v = 1; v < 13; v++) begin wr('h10, bcd(v)); rd('h10, rv); chk("R2 mon", rv, bcd(v)); end
    for (int v = 0; v < 100; v++) begin
      wr('h14, bcd(v)); rd('h14, rv); chk("R2 year", rv, bcd(v));
      chk("R11 year_o", year_o, bcd(v));
    end
    rd('h1C, rv); chk("R2 unmapped", rv, 0);
    rd('h3C, rv); chk("R2 unmapped", rv, 0);

    // R3 weekday write ignored
    wr('h18, 5); rd('h18, rv); chk("R3 wday", rv, 0); chk("R3 wday_o", wday_o, 0);

    // R4 control layout
    wr('h40, 'h0C); rd('h40, rv); chk("R4 ctrl", rv, 'h0C); chk("R4 acomp", acomp_en_o, 1);
    wr('h40, 'h05); rd('h40, rv); chk("R4 ctrl", rv, 'h05);
    wr('h40, 'h00); chk("R4 acomp", acomp_en_o, 0);

    // R8 12-hour presentation and writes
    for (int h = 0; h < 24; h++) begin
      wr('h40, 0); wr('h08, bcd(h));
      wr('h40, 'h08); rd('h08, rv); chk("R8 read12", rv, fmt12(h));
      wr('h08, 0); wr('h08, fmt12(h)); chk("R8 write12", hour_o, bcd(h));
    end
    wr('h40, 0);

    // R5 stopped / running
    set_all(10, 3, 5, 10, 20, 30);
    tk(); chk("R5 stopped", sec_o, 'h30); chk("R5 stopped min", min_o, 'h20);
    wr('h40, 1); tk(); chk("R5 running", sec_o, 'h31);
    set_all(10, 3, 5, 0, 0, 0);
    for (int i = 1; i <= 130; i++) begin
      tk();
      chk("R5 sec_o", sec_o, bcd(i % 60));
      chk("R6 min_o", min_o, bcd(i / 60));
      chk("R6 sec_wrap", sec_wrap_o, (i % 60 == 0) ? 1 : 0);
    end

    // R6 R7 full cascade
    set_all(99, 12, 31, 23, 59, 59);
    tk();
    exp_wd = (exp_wd + 1) % 7;
    chk("R6 sec", sec_o, 0); chk("R6 min", min_o, 0); chk("R6 hour", hour_o, 0);
    chk("R7 day", day_o, 1); chk("R7 mon", mon_o, 1); chk("R7 year", year_o, 0);
    chk("R7 wday", wday_o, exp_wd);
    chk("R6 strobes", {sec_wrap_o, min_wrap_o, hour_wrap_o, day_wrap_o}, 'hF);
    @(negedge clk);
    chk("R6 strobes one cycle", {sec_wrap_o, min_wrap_o, hour_wrap_o, day_wrap_o}, 0);

    // R7 month lengths over a leap cycle
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        set_all(y, m, dim(m, y), 23, 59, 59);
        tk();
        exp_wd = (exp_wd + 1) % 7;
        chk("R7 day wrap", day_o, 1);
        chk("R7 mon next", mon_o, bcd(m == 12 ? 1 : m + 1));
        chk("R7 year next", year_o, bcd(m == 12 ? y + 1 : y));
        chk("R7 day_wrap", day_wrap_o, 1);
        chk("R7 wday", wday_o, exp_wd);
        if (m == 2) begin
          set_all(y, 2, 28, 23, 59, 59);
          tk();
          if (y % 4 == 0) begin
            chk("R7 leap 29", day_o, 'h29); chk("R7 leap mon", mon_o, 2);
          end else begin
            exp_wd = (exp_wd + 1) % 7;
            chk("R7 feb wrap", day_o, 1); chk("R7 feb mon", mon_o, 3);
          end
          chk("R7 wday feb", wday_o, exp_wd);
        end
      end
    end

    // R9 round across every seconds value
    for (int s = 0; s < 60; s++) begin
      set_all(20, 6, 15, 5, 10, s);
      wr('h40, 'h03);
      tk();
      chk("R9 sec", sec_o, 0);
      chk("R9 min", min_o, (s >= 30) ? 'h11 : 'h10);
      chk("R9 strobe", sec_wrap_o, (s >= 30) ? 1 : 0);
      rd('h40, rv); chk("R9 self clear", rv, 'h01);
    end
    set_all(20, 6, 15, 5, 10, 45);
    wr('h40, 'h02); tk();
    chk("R9 stopped sec", sec_o, 0); chk("R9 stopped min", min_o, 'h11);
    rd('h40, rv); chk("R9 stopped clear", rv, 0);

    // R10 tick colliding with a write is deferred
    wr('h40, 1); set_all(20, 6, 15, 5, 10, 5);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 7'h04; wdata = 8'h20;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R10 held sec", sec_o, 'h05); chk("R10 write min", min_o, 'h20);
    @(negedge clk);
    chk("R10 deferred sec", sec_o, 'h06);
    @(negedge clk);
    chk("R10 single step", sec_o, 'h06);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule